// File: doc/BRIEF.md
# Adaptive Tagged Sequential Prefetcher

This block sits next to a data cache and watches its access stream. When a demand miss brings in a block, or when a block that was prefetched earlier is touched for the first time, the block looks at the next K block addresses. It requests each one that is not already cached, in ascending order and one per cycle, through a ready/valid request port. The block keeps its own presence bitmap of the block-address space. That bitmap is filled by accesses and by accepted requests, and it is cleared by the cache's eviction notices. The per-line "prefetched, not yet used" tag belongs to the cache and is presented with each access.

The lookahead degree K is not fixed. Over each epoch of a fixed number of issued prefetches, the block counts how many first-use hits on prefetched blocks it sees. If that share is above an upper ratio, K grows by one, up to a maximum. If it is below a lower ratio, K shrinks by one. At K = 0 nothing is issued. A separate detector then counts, over windows of a fixed number of misses, the misses whose preceding block is cached, and it restores K to 1 once that share rises above the lower ratio. A configuration input selects a simpler prefetch-on-miss policy instead. Under that policy only demand misses trigger, and they trigger a single candidate.

While a trigger's candidates are still being worked through, the block raises `busy`. Upstream logic must hold further accesses until `busy` falls. Accesses presented while it is high are dropped.

Top module: `seq_stream_pf`

## Requirements
- R1: After synchronous reset, `degree` is 1, `pf_valid` and `busy` are 0, and the presence bitmap is empty.
- R2: With `cfg_on_miss` = 0, an accepted access triggers when `acc_hit` = 0, or when `acc_hit` = 1 with `acc_first` = 1. A hit with `acc_first` = 0 does not trigger.
- R3: A trigger on block b with degree K > 0 raises `busy` on the next cycle and walks candidates b+1 … b+K, modulo 2^AW, in ascending order at one per cycle. A candidate that is not present is offered on `pf_blk` with `pf_valid`. A candidate that is present is skipped without a request, and the skip takes one cycle.
- R4: While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_blk` holds its value.
- R5: `busy` falls on the edge that consumes the last candidate. An access presented while `busy` is high is ignored: it causes no trigger, no presence update and no counting.
- R6: A block becomes present when it is accessed or when its request is accepted. It becomes absent on `evict_valid`. If both happen to the same block in one cycle, the block ends up present.
- R7: With `cfg_on_miss` = 1, only an access with `acc_hit` = 0 triggers, and it offers only b+1, whatever K is.
- R8: Once EPOCH requests have been accepted, the epoch closes on the following edge. If useful·DEN > HI_NUM·EPOCH, K rises by one, saturating at KMAX. A useful event is an accepted access with `acc_hit` = 1 and `acc_first` = 1.
- R9: At epoch close, if useful·DEN < LO_NUM·EPOCH, K falls by one. With K = 0, no trigger starts a walk and `busy` stays low.
- R10: While K = 0, misses are counted in windows of WIN. A miss is sequential when block b−1 is present at that time. When a window closes with sequential·DEN > LO_NUM·WIN, K becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_on_miss | input | 1 | 0: tagged policy, 1: prefetch-on-miss policy |
| acc_valid | input | 1 | A cache access is presented this cycle |
| acc_blk | input | AW | Block address of the access |
| acc_hit | input | 1 | 1 when the access hit in the cache |
| acc_first | input | 1 | 1 when the hit line was prefetched and is used for the first time |
| evict_valid | input | 1 | The cache dropped a block this cycle |
| evict_blk | input | AW | Block address of the dropped block |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | The memory side accepts the offered request |
| pf_blk | output | AW | Block address of the offered request |
| busy | output | 1 | A candidate walk is in progress; accesses are not taken |
| degree | output | $clog2(KMAX+1) | Current lookahead degree K |

## Verification
Every result of an access appears one edge after the edge that samples it. On the following cycle, `busy` and the first candidate's `pf_valid`/`pf_blk` are visible. Each later candidate follows one edge after the previous one is accepted or skipped. A degree change shows one edge after the cycle in which the EPOCH-th request was accepted or the WIN-th miss was counted. The bench keeps a behavioural model that applies the same rules on each rising edge, using the inputs that were driven in the middle of the previous cycle. It then compares `busy`, `pf_valid`, `pf_blk` and `degree` with the model at every falling edge. Directed checks read the ports one delta after the edge that captures the stimulus, so each one sees exactly the first cycle in which its result is due.

// File: rtl/spf_pkg.sv
package spf_pkg;

    // Trigger policy selected by the configuration input.
    typedef enum logic {
        MODE_TAGGED  = 1'b0,
        MODE_ON_MISS = 1'b1
    } pf_mode_e;

    // Per-cycle classification of the presented access.
    typedef struct packed {
        logic take;    // access accepted (block not busy)
        logic trig;    // access starts a candidate walk
        logic useful;  // first-use hit on a prefetched line
        logic miss;    // demand miss
        logic seq;     // miss whose predecessor block is present
    } acc_evt_t;

    // part/whole compared with num/den by cross-multiplication.
    function automatic logic ratio_gt(input int unsigned part, input int unsigned den,
                                      input int unsigned num, input int unsigned whole);
        return (part * den) > (num * whole);
    endfunction

    function automatic logic ratio_lt(input int unsigned part, input int unsigned den,
                                      input int unsigned num, input int unsigned whole);
        return (part * den) < (num * whole);
    endfunction

endpackage

// File: rtl/spf_presence.sv
module spf_presence #(
    parameter int unsigned AW = 8,
    localparam int unsigned NB = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fill_a_en,
    input  logic [AW-1:0] fill_a_blk,
    input  logic          fill_b_en,
    input  logic [AW-1:0] fill_b_blk,
    input  logic          drop_en,
    input  logic [AW-1:0] drop_blk,
    input  logic [AW-1:0] look_a_blk,
    output logic          look_a_hit,
    input  logic [AW-1:0] look_b_blk,
    output logic          look_b_hit
);

    logic [NB-1:0] map_q;
    logic [NB-1:0] map_d;

    // Fills are applied after the drop so a same-cycle fill wins.
    always_comb begin
        map_d = map_q;
        if (drop_en)   map_d[drop_blk]   = 1'b0;
        if (fill_a_en) map_d[fill_a_blk] = 1'b1;
        if (fill_b_en) map_d[fill_b_blk] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) map_q <= '0;
        else     map_q <= map_d;
    end

    assign look_a_hit = map_q[look_a_blk];
    assign look_b_hit = map_q[look_b_blk];

    AST_FILL_MARKS: assert property (@(posedge clk) disable iff (rst)
        fill_b_en |=> map_q[$past(fill_b_blk)]); // R6

endmodule

// File: rtl/spf_issue.sv
module spf_issue #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_blk,
    input  logic [DW-1:0] start_cnt,
    input  logic          cur_present,
    input  logic          req_ready,
    output logic          busy,
    output logic [AW-1:0] cur_blk,
    output logic          req_valid,
    output logic          fire
);

    logic [DW-1:0] left_q;
    logic          busy_q;
    logic [AW-1:0] cur_q;
    logic          advance;

    assign req_valid = busy_q & ~cur_present;
    assign fire      = req_valid & req_ready;
    assign advance   = busy_q & (~req_valid | req_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cur_q  <= '0;
            left_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cur_q  <= start_blk + AW'(1);
            left_q <= start_cnt;
        end else if (advance) begin
            if (left_q == DW'(1)) begin
                busy_q <= 1'b0;
            end else begin
                cur_q  <= cur_q + AW'(1);
                left_q <= left_q - DW'(1);
            end
        end
    end

    assign busy    = busy_q;
    assign cur_blk = cur_q;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !req_valid); // R5

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(cur_q))); // R4

    AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q); // R5

endmodule

// File: rtl/spf_degree.sv
module spf_degree
    import spf_pkg::*;
#(
    parameter int unsigned KMAX   = 8,
    parameter int unsigned EPOCH  = 256,
    parameter int unsigned WIN    = 64,
    parameter int unsigned HI_NUM = 3,
    parameter int unsigned LO_NUM = 1,
    parameter int unsigned DEN    = 4,
    localparam int unsigned DW = $clog2(KMAX + 1),
    localparam int unsigned IW = $clog2(EPOCH + 1),
    localparam int unsigned MW = $clog2(WIN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic          useful,
    input  logic          miss,
    input  logic          seqm,
    output logic [DW-1:0] degree
);

    logic [DW-1:0] k_q;
    logic [IW-1:0] iss_q;
    logic [IW-1:0] use_q;
    logic [MW-1:0] mis_q;
    logic [MW-1:0] seq_q;
    logic          ep_close;
    logic          win_close;
    logic          go_up;
    logic          go_down;
    logic          revive;

    assign ep_close  = (iss_q == IW'(EPOCH));
    assign win_close = (mis_q == MW'(WIN));
    assign go_up     = ratio_gt(32'(use_q), DEN, HI_NUM, EPOCH) && (k_q < DW'(KMAX));
    assign go_down   = ratio_lt(32'(use_q), DEN, LO_NUM, EPOCH);
    assign revive    = ratio_gt(32'(seq_q), DEN, LO_NUM, WIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            k_q   <= DW'(1);
            iss_q <= '0;
            use_q <= '0;
            mis_q <= '0;
            seq_q <= '0;
        end else if (k_q != '0) begin
            // Prefetching active: efficiency epochs, detector idle.
            mis_q <= '0;
            seq_q <= '0;
            if (ep_close) begin
                if (go_up)        k_q <= k_q + DW'(1);
                else if (go_down) k_q <= k_q - DW'(1);
                iss_q <= IW'(fire);
                use_q <= IW'(useful);
            end else begin
                iss_q <= iss_q + IW'(fire);
                if (use_q != IW'(EPOCH)) use_q <= use_q + IW'(useful);
            end
        end else begin
            // Prefetching off: sequential-miss windows.
            iss_q <= '0;
            use_q <= '0;
            if (win_close) begin
                if (revive) k_q <= DW'(1);
                mis_q <= MW'(miss);
                seq_q <= MW'(seqm);
            end else begin
                mis_q <= mis_q + MW'(miss);
                seq_q <= seq_q + MW'(seqm);
            end
        end
    end

    assign degree = k_q;

    AST_DEGREE_CAP: assert property (@(posedge clk) disable iff (rst)
        k_q <= DW'(KMAX)); // R8

    AST_EPOCH_BOUND: assert property (@(posedge clk) disable iff (rst)
        iss_q <= IW'(EPOCH)); // R8

    AST_DEGREE_STEP: assert property (@(posedge clk) disable iff (rst)
        (k_q != $past(k_q)) |-> ((k_q == $past(k_q) + DW'(1)) || (k_q + DW'(1) == $past(k_q)))); // R9

    AST_SEQ_LE_MISS: assert property (@(posedge clk) disable iff (rst)
        seq_q <= mis_q); // R10

endmodule

// File: rtl/seq_stream_pf.sv
module seq_stream_pf
    import spf_pkg::*;
#(
    parameter int unsigned AW     = 8,
    parameter int unsigned KMAX   = 8,
    parameter int unsigned EPOCH  = 256,
    parameter int unsigned WIN    = 64,
    parameter int unsigned HI_NUM = 3,
    parameter int unsigned LO_NUM = 1,
    parameter int unsigned DEN    = 4,
    localparam int unsigned DW = $clog2(KMAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_on_miss,
    input  logic          acc_valid,
    input  logic [AW-1:0] acc_blk,
    input  logic          acc_hit,
    input  logic          acc_first,
    input  logic          evict_valid,
    input  logic [AW-1:0] evict_blk,
    output logic          pf_valid,
    input  logic          pf_ready,
    output logic [AW-1:0] pf_blk,
    output logic          busy,
    output logic [DW-1:0] degree
);

    pf_mode_e      mode;
    acc_evt_t      evt;
    logic          busy_w;
    logic          fire_w;
    logic [AW-1:0] cur_w;
    logic          cur_present;
    logic          prev_present;
    logic [AW-1:0] prev_blk;
    logic [DW-1:0] degree_w;
    logic          start;
    logic [DW-1:0] start_cnt;

    assign mode     = pf_mode_e'(cfg_on_miss);
    assign prev_blk = acc_blk - AW'(1);

    always_comb begin
        evt.take   = acc_valid & ~busy_w;
        evt.miss   = evt.take & ~acc_hit;
        evt.useful = evt.take & acc_hit & acc_first;
        evt.seq    = evt.miss & prev_present;
        if (mode == MODE_ON_MISS) evt.trig = evt.miss;
        else                      evt.trig = evt.miss | evt.useful;
    end

    assign start     = evt.trig & (degree_w != '0);
    assign start_cnt = (mode == MODE_ON_MISS) ? DW'(1) : degree_w;

    spf_presence #(.AW(AW)) u_presence (
        .clk        (clk),
        .rst        (rst),
        .fill_a_en  (evt.take),
        .fill_a_blk (acc_blk),
        .fill_b_en  (fire_w),
        .fill_b_blk (cur_w),
        .drop_en    (evict_valid),
        .drop_blk   (evict_blk),
        .look_a_blk (cur_w),
        .look_a_hit (cur_present),
        .look_b_blk (prev_blk),
        .look_b_hit (prev_present)
    );

    spf_issue #(.AW(AW), .DW(DW)) u_issue (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_blk   (acc_blk),
        .start_cnt   (start_cnt),
        .cur_present (cur_present),
        .req_ready   (pf_ready),
        .busy        (busy_w),
        .cur_blk     (cur_w),
        .req_valid   (pf_valid),
        .fire        (fire_w)
    );

    spf_degree #(
        .KMAX   (KMAX),
        .EPOCH  (EPOCH),
        .WIN    (WIN),
        .HI_NUM (HI_NUM),
        .LO_NUM (LO_NUM),
        .DEN    (DEN)
    ) u_degree (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire_w),
        .useful (evt.useful),
        .miss   (evt.miss),
        .seqm   (evt.seq),
        .degree (degree_w)
    );

    assign pf_blk = cur_w;
    assign busy   = busy_w;
    assign degree = degree_w;

    AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (rst)
        (degree_w == '0 && !busy_w) |=> !busy_w); // R9

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (busy_w && acc_valid) |-> !start); // R5

endmodule

// File: tb/seq_stream_pf_test.sv
module seq_stream_pf_test;

    localparam int AW = 6;
    localparam int NB = 1 << AW;
    localparam int KMAX = 4;
    localparam int EPOCH = 8;
    localparam int WIN = 8;
    localparam int HI_NUM = 3;
    localparam int LO_NUM = 1;
    localparam int DEN = 4;
    localparam int DW = $clog2(KMAX + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_on_miss = 1'b0;
    logic          acc_valid = 1'b0;
    logic [AW-1:0] acc_blk = '0;
    logic          acc_hit = 1'b0;
    logic          acc_first = 1'b0;
    logic          evict_valid = 1'b0;
    logic [AW-1:0] evict_blk = '0;
    logic          pf_valid;
    logic          pf_ready = 1'b1;
    logic [AW-1:0] pf_blk;
    logic          busy;
    logic [DW-1:0] degree;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    seq_stream_pf #(
        .AW(AW), .KMAX(KMAX), .EPOCH(EPOCH), .WIN(WIN),
        .HI_NUM(HI_NUM), .LO_NUM(LO_NUM), .DEN(DEN)
    ) uut (
        .clk(clk), .rst(rst), .cfg_on_miss(cfg_on_miss),
        .acc_valid(acc_valid), .acc_blk(acc_blk), .acc_hit(acc_hit), .acc_first(acc_first),
        .evict_valid(evict_valid), .evict_blk(evict_blk),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_blk(pf_blk),
        .busy(busy), .degree(degree)
    );

    // ---------------- behavioural reference (also the cache's line state) ----
    bit m_pres[NB];
    bit m_tag[NB];
    bit m_busy;
    int m_cur, m_rem, m_k, m_iss, m_use, m_ms, m_sq;
    bit take, trig, rv, fire, useful, miss, seqm;
    int b, fcur, k_old;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NB; i++) begin m_pres[i] = 0; m_tag[i] = 0; end
            m_busy = 0; m_cur = 0; m_rem = 0; m_k = 1;
            m_iss = 0; m_use = 0; m_ms = 0; m_sq = 0;
        end else begin
            b      = int'(acc_blk);
            take   = acc_valid && !m_busy;
            miss   = take && !acc_hit;
            useful = take && acc_hit && acc_first;
            trig   = cfg_on_miss ? miss : (miss || useful);
            seqm   = miss && m_pres[(b + NB - 1) % NB];
            rv     = m_busy && !m_pres[m_cur];
            fire   = rv && pf_ready;
            fcur   = m_cur;
            k_old  = m_k;
            if (m_busy && (!rv || pf_ready)) begin
                if (m_rem == 1) m_busy = 0;
                else begin m_cur = (m_cur + 1) % NB; m_rem = m_rem - 1; end
            end
            if (trig && k_old != 0) begin
                m_busy = 1; m_cur = (b + 1) % NB; m_rem = cfg_on_miss ? 1 : k_old;
            end
            if (evict_valid) begin m_pres[evict_blk] = 0; m_tag[evict_blk] = 0; end
            if (take) begin m_pres[b] = 1; m_tag[b] = 0; end
            if (fire) begin m_pres[fcur] = 1; m_tag[fcur] = 1; end
            if (k_old != 0) begin
                m_ms = 0; m_sq = 0;
                if (m_iss == EPOCH) begin
                    if (m_use * DEN > HI_NUM * EPOCH && k_old < KMAX) m_k = k_old + 1;
                    else if (m_use * DEN < LO_NUM * EPOCH) m_k = k_old - 1;
                    m_iss = int'(fire); m_use = int'(useful);
                end else begin
                    m_iss = m_iss + int'(fire);
                    if (m_use < EPOCH) m_use = m_use + int'(useful);
                end
            end else begin
                m_iss = 0; m_use = 0;
                if (m_ms == WIN) begin
                    if (m_sq * DEN > LO_NUM * WIN) m_k = 1;
                    m_ms = int'(miss); m_sq = int'(seqm);
                end else begin
                    m_ms = m_ms + int'(miss); m_sq = m_sq + int'(seqm);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference, away from the rising edge.
    always @(negedge clk) begin
        if (!rst) begin
            chk(busy == m_busy, "R5 busy", int'(busy), int'(m_busy));
            chk(pf_valid == (m_busy && !m_pres[m_cur]), "R3 pf_valid",
                int'(pf_valid), int'(m_busy && !m_pres[m_cur]));
            if (pf_valid) chk(int'(pf_blk) == m_cur, "R3 pf_blk", int'(pf_blk), m_cur);
            chk(int'(degree) == m_k, "R8 degree", int'(degree), m_k);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL R5 watchdog cycles=%0d expected<=100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic acc(input int blk, input bit h, input bit f);
        @(posedge clk); #1;
        acc_valid = 1; acc_blk = AW'(blk); acc_hit = h; acc_first = f;
        @(posedge clk); #1;
        acc_valid = 0;
    endtask

    task automatic cacc(input int blk, input bit do_ev, input int evb);
        @(posedge clk); #1;
        acc_valid = 1; acc_blk = AW'(blk); acc_hit = m_pres[blk]; acc_first = m_tag[blk];
        evict_valid = do_ev; evict_blk = AW'(evb);
        @(posedge clk); #1;
        acc_valid = 0; evict_valid = 0;
    endtask

    task automatic ev(input int blk);
        @(posedge clk); #1;
        evict_valid = 1; evict_blk = AW'(blk);
        @(posedge clk); #1;
        evict_valid = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 0;
        // R1: reset state
        chk(degree == DW'(1), "R1 degree", int'(degree), 1);
        chk(!pf_valid, "R1 pf_valid", int'(pf_valid), 0);
        chk(!busy, "R1 busy", int'(busy), 0);

        // R2/R3: miss triggers next block
        acc(10, 0, 0);
        chk(busy && pf_valid, "R2 miss trigger", int'(pf_valid), 1);
        chk(pf_blk == AW'(11), "R3 first candidate", int'(pf_blk), 11);
        wait_idle();
        acc(11, 1, 1);
        chk(pf_valid && pf_blk == AW'(12), "R2 first-use trigger", int'(pf_blk), 12);
        wait_idle();
        acc(12, 1, 1);
        chk(pf_valid && pf_blk == AW'(13), "R2 first-use trigger", int'(pf_blk), 13);
        wait_idle();
        acc(11, 1, 0);
        chk(!busy, "R2 plain hit no trigger", int'(busy), 0);

        // R3/R6: present candidate skipped
        acc(21, 0, 0);
        wait_idle();
        acc(20, 0, 0);
        chk(busy && !pf_valid, "R3 present skipped", int'(pf_valid), 0);
        wait_idle();

        // R4: hold under back-pressure; R5: access during busy ignored
        pf_ready = 0;
        acc(40, 0, 0);
        repeat (3) @(posedge clk);
        #1 chk(pf_valid && pf_blk == AW'(41), "R4 held request", int'(pf_blk), 41);
        acc(50, 0, 0);
        chk(busy && pf_blk == AW'(41), "R5 no restart while busy", int'(pf_blk), 41);
        pf_ready = 1;
        wait_idle();
        acc(49, 0, 0);
        chk(pf_valid && pf_blk == AW'(50), "R5 ignored access left no presence", int'(pf_blk), 50);
        wait_idle();

        // R6: eviction clears, same-cycle fill wins
        ev(50);
        acc(49, 0, 0);
        chk(pf_valid && pf_blk == AW'(50), "R6 evicted block requested", int'(pf_blk), 50);
        wait_idle();
        @(posedge clk); #1;
        acc_valid = 1; acc_blk = AW'(55); acc_hit = 0; acc_first = 0;
        evict_valid = 1; evict_blk = AW'(55);
        @(posedge clk); #1;
        acc_valid = 0; evict_valid = 0;
        wait_idle();
        acc(54, 0, 0);
        chk(busy && !pf_valid, "R6 fill beats eviction", int'(pf_valid), 0);
        wait_idle();

        // R7: prefetch-on-miss policy
        cfg_on_miss = 1;
        acc(0, 0, 0);
        chk(pf_valid && pf_blk == AW'(1), "R7 miss trigger", int'(pf_blk), 1);
        wait_idle();
        acc(1, 1, 1);
        chk(!busy, "R7 first-use hit ignored", int'(busy), 0);
        cfg_on_miss = 0;

        // R8: useful sequential stream raises K to KMAX
        for (int i = 0; i < 160; i++) begin
            wait_idle();
            cacc(i % NB, 1, (i + NB - 12) % NB);
        end
        wait_idle();
        chk(degree == DW'(KMAX), "R8 degree saturates", int'(degree), KMAX);

        // R7: single candidate in miss mode even with K above 1
        cfg_on_miss = 1;
        ev(30);
        ev(31);
        acc(30, 0, 0);
        chk(pf_valid && pf_blk == AW'(31), "R7 single candidate", int'(pf_blk), 31);
        @(posedge clk); #1;
        chk(!busy, "R7 walk ends after one", int'(busy), 0);
        cfg_on_miss = 0;

        // R9: useless prefetches drive K to 0
        for (int i = 0; i < 300 && degree != 0; i++) begin
            wait_idle();
            ev((i * 11) % NB);
            acc((i * 11) % NB, 0, 0);
        end
        wait_idle();
        chk(degree == 0, "R9 degree reaches zero", int'(degree), 0);
        ev(33);
        acc(33, 0, 0);
        chk(!busy && !pf_valid, "R9 no walk at zero", int'(busy), 0);

        // R10: sequential misses restore K
        for (int i = 0; i < 40 && degree == 0; i++) begin
            ev((40 + i) % NB);
            acc((40 + i) % NB, 0, 0);
        end
        chk(degree == DW'(1), "R10 degree restored", int'(degree), 1);
        wait_idle();
        ev(5);
        ev(6);
        acc(5, 0, 0);
        chk(pf_valid && pf_blk == AW'(6), "R10 prefetch resumes", int'(pf_blk), 6);
        wait_idle();

        repeat (4) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule